// File: doc/BRIEF.md
# Single-Wire Bus Slot Timer

This block drives an open-drain single-wire bus at the level of individual timed slots. A command selects one primitive: a bus reset with presence detection, a slot that writes a bit, a "touch" that either reads or writes a zero depending on its data bit, or a plain read slot. The engine pulls the line low, releases it, samples it where the primitive needs a sample, waits out the recovery time and then returns one result bit. Byte assembly, device search and checksums belong to the caller.

Every slot is built from three consecutive intervals: a low phase, a released phase that ends at the sample point, and a released tail. A microsecond prescaler, sized by the `CLKS_PER_US` parameter, times them. Each interval is multiplied by a stretch factor that is taken from `stretch_i` when a command is accepted, so slow or long buses can be timed without changing the design.

Commands enter on a valid/ready handshake. `cmd_ready` is high only while the engine is idle. The result leaves on a second valid/ready handshake. `rsp_valid` stays high with a steady bit until `rsp_ready` takes it, and no new command is accepted before that. The bus input passes through a synchronizer before it is sampled.

Top module: `owslot_engine`

## Requirements
- R1: After reset the engine is idle: `cmd_ready`=1, `busy`=0, `rsp_valid`=0 and `line_pull_low`=0.
- R2: `cmd_op`=1 with `cmd_bit`=1 (write a one) holds `line_pull_low` for 6 µs and presents the response 70 µs after acceptance with result 0.
- R3: `cmd_op`=1 with `cmd_bit`=0 (write a zero) holds `line_pull_low` for 60 µs and presents the response 70 µs after acceptance with result 0.
- R4: `cmd_op`=3 (read, data bit ignored) holds the line low for 6 µs, samples the synchronized line 15 µs after acceptance, responds at 70 µs and returns the sampled level.
- R5: `cmd_op`=0 (bus reset) holds the line low for 500 µs and samples the line 570 µs after acceptance. It responds at 1000 µs, which leaves 430 µs of quiet bus after the sample. The result is 0 when the line was low at the sample (device present) and 1 when it was high (absent).
- R6: `cmd_op`=2 (touch) with `cmd_bit`=1 behaves exactly as a read slot and returns the sample. With `cmd_bit`=0 it behaves as a write-zero slot and returns 0.
- R7: Every interval is multiplied by the `stretch_i` value captured at acceptance. A captured value of 0 is treated as 1.
- R8: `cmd_ready` is high only when idle. A `cmd_valid` raised while the engine is busy starts nothing, and the engine returns to idle after the current response.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high, `rsp_bit` stays stable and `busy` stays high. The cycle after the handshake, the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stretch_i | input | SCALE_W | Interval multiplier, captured at command acceptance |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| cmd_op | input | 2 | 0 reset, 1 write, 2 touch, 3 read |
| cmd_bit | input | 1 | Data bit for write and touch |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result consumed |
| rsp_bit | output | 1 | Sampled bit, presence flag (0 = present), or 0 |
| busy | output | 1 | High from acceptance until the result is taken |
| line_pull_low | output | 1 | Drive the open-drain line low when high |
| line_in | input | 1 | Level on the bus line |

## Verification
The assertions assume that `line_in` always carries a defined level and that the response side eventually raises `rsp_ready`. The hold property covers only the stall window, so a consumer that never answers leaves the engine parked legally in its response state. The stimulus models the bus as a wired-AND of the engine's pull-down and a device pull-down. The device changes its drive only on falling clock edges, in windows whose edges lie many microseconds from any sample point. The synchronizer delay therefore never decides a result.

// File: rtl/owslot_pkg.sv
package owslot_pkg;

  localparam int DUR_W = 10;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_TOUCH = 2'd2,
    OP_READ  = 2'd3
  } ow_op_e;

  typedef enum logic [1:0] {
    SK_RST,
    SK_WR0,
    SK_WR1,
    SK_RD
  } slot_e;

  typedef enum logic [1:0] {
    PH_LOW,
    PH_MID,
    PH_TAIL
  } phase_e;

  // Interval length in microseconds for one phase of one slot kind.
  function automatic logic [DUR_W-1:0] slot_us(slot_e k, phase_e p);
    logic [DUR_W-1:0] r;
    case (k)
      SK_RST:  r = (p == PH_LOW) ? 10'd500 : (p == PH_MID) ? 10'd70 : 10'd430;
      SK_WR0:  r = (p == PH_LOW) ? 10'd60  : (p == PH_MID) ? 10'd5  : 10'd5;
      default: r = (p == PH_LOW) ? 10'd6   : (p == PH_MID) ? 10'd9  : 10'd55;
    endcase
    return r;
  endfunction

  // Map an operation and its data bit onto the slot that is generated.
  function automatic slot_e decode(ow_op_e op, logic b);
    slot_e k;
    case (op)
      OP_RESET: k = SK_RST;
      OP_WRITE: k = b ? SK_WR1 : SK_WR0;
      OP_TOUCH: k = b ? SK_RD : SK_WR0;
      default:  k = SK_RD;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/owslot_sync.sv
module owslot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '1;
        else        sr <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/owslot_interval.sv
module owslot_interval #(
  parameter int CLKS_PER_US = 125,
  parameter int CNT_W       = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_us,
  output logic             expire
);
  localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

  logic [PRE_W-1:0] presc;
  logic [CNT_W-1:0] remain_us;
  logic             tick;

  assign tick   = (presc == PRE_LAST);
  assign expire = (remain_us == CNT_W'(1)) && tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc     <= '0;
      remain_us <= '0;
    end else if (load) begin
      presc     <= '0;
      remain_us <= load_us;
    end else if (remain_us != '0) begin
      if (tick) begin
        presc     <= '0;
        remain_us <= remain_us - CNT_W'(1);
      end else begin
        presc <= presc + PRE_W'(1);
      end
    end
  end

  // R7: an exhausted interval stays exhausted until it is reloaded
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (remain_us == '0 && !load) |=> (remain_us == '0));

  // R7: a load with a non-zero length always leaves a running interval
  p_load_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_us != '0) |=> (remain_us != '0));
endmodule

// File: rtl/owslot_engine.sv
module owslot_engine
  import owslot_pkg::*;
#(
  parameter int CLKS_PER_US = 125,
  parameter int SCALE_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SCALE_W-1:0] stretch_i,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic               cmd_bit,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_bit,
  output logic               busy,
  output logic               line_pull_low,
  input  logic               line_in
);
  localparam int CNT_W = DUR_W + SCALE_W;

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_MID, S_TAIL, S_RESP} st_e;

  st_e                state;
  slot_e              kind_q, new_kind, ld_kind;
  phase_e             ld_phase;
  logic [SCALE_W-1:0] scale_q, eff_in, ld_scale;
  logic               cap_q, bit_q, accept, tm_load, tm_expire, line_s;
  logic [CNT_W-1:0]   tm_len;

  owslot_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  owslot_interval #(.CLKS_PER_US(CLKS_PER_US), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_us(tm_len), .expire(tm_expire)
  );

  assign cmd_ready     = (state == S_IDLE);
  assign accept        = cmd_valid && cmd_ready;
  assign busy          = (state != S_IDLE);
  assign rsp_valid     = (state == S_RESP);
  assign rsp_bit       = bit_q;
  assign line_pull_low = (state == S_LOW);
  assign new_kind      = decode(ow_op_e'(cmd_op), cmd_bit);
  assign eff_in        = (stretch_i == '0) ? SCALE_W'(1) : stretch_i;

  always_comb begin
    tm_load  = 1'b0;
    ld_kind  = kind_q;
    ld_phase = PH_LOW;
    ld_scale = scale_q;
    case (state)
      S_IDLE: if (accept) begin
        tm_load  = 1'b1;
        ld_kind  = new_kind;
        ld_scale = eff_in;
      end
      S_LOW: if (tm_expire) begin
        tm_load  = 1'b1;
        ld_phase = PH_MID;
      end
      S_MID: if (tm_expire) begin
        tm_load  = 1'b1;
        ld_phase = PH_TAIL;
      end
      default: ;
    endcase
  end

  assign tm_len = CNT_W'(slot_us(ld_kind, ld_phase)) * CNT_W'(ld_scale);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      kind_q  <= SK_RD;
      scale_q <= SCALE_W'(1);
      cap_q   <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state   <= S_LOW;
          kind_q  <= new_kind;
          scale_q <= eff_in;
          cap_q   <= (new_kind == SK_RST) || (new_kind == SK_RD);
          bit_q   <= 1'b0;
        end
        S_LOW:  if (tm_expire) state <= S_MID;
        S_MID:  if (tm_expire) begin
          state <= S_TAIL;
          bit_q <= cap_q ? line_s : 1'b0;
        end
        S_TAIL: if (tm_expire) state <= S_RESP;
        default: if (rsp_ready) state <= S_IDLE;
      endcase
    end
  end

  // R1: the line is only ever pulled while a command is in progress
  p_pull_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull_low |-> busy);

  // R8: an accepted command starts its low phase on the next cycle
  p_accept_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && line_pull_low));

  // R8: ready and a pending result never coexist
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!busy && !rsp_valid));

  // R9: a stalled result keeps its value
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_bit)));

  // R6: slots that do not sample report zero
  p_nodata_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !cap_q) |-> !rsp_bit);
endmodule

// File: tb/tb_owslot_engine.sv
`timescale 1ns/1ps
module tb_owslot_engine;
  localparam int CPU = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] stretch_i = 4'd1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic       cmd_bit = 1'b0;
  logic       rsp_ready = 1'b1;
  logic       dev_low = 1'b0;
  logic       cmd_ready, rsp_valid, rsp_bit, busy, line_pull_low, line_in;
  int         checks = 0;
  int         fails = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  assign line_in = !(line_pull_low || dev_low);

  owslot_engine #(.CLKS_PER_US(CPU), .SCALE_W(4), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .stretch_i(stretch_i), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_bit(rsp_bit),
    .busy(busy), .line_pull_low(line_pull_low), .line_in(line_in)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        bt;
    logic [3:0]  st;
    logic [1:0]  dev;     // 0 silent, 1 low for first 20 us, 2 pulse 530..650 us
    logic [9:0]  low_us;
    logic [10:0] tot_us;
    logic        exp_bit;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 4'd1, 2'd2, 10'd500, 11'd1000, 1'b0, 4'd5}, // R5 present
    '{2'd0, 1'b0, 4'd1, 2'd0, 10'd500, 11'd1000, 1'b1, 4'd5}, // R5 absent
    '{2'd1, 1'b1, 4'd1, 2'd0, 10'd6,   11'd70,   1'b0, 4'd2}, // R2
    '{2'd1, 1'b0, 4'd1, 2'd2, 10'd60,  11'd70,   1'b0, 4'd3}, // R3
    '{2'd3, 1'b0, 4'd1, 2'd1, 10'd6,   11'd70,   1'b0, 4'd4}, // R4 line low
    '{2'd3, 1'b1, 4'd1, 2'd0, 10'd6,   11'd70,   1'b1, 4'd4}, // R4 line high
    '{2'd2, 1'b1, 4'd1, 2'd1, 10'd6,   11'd70,   1'b0, 4'd6}, // R6 touch one, low
    '{2'd2, 1'b1, 4'd1, 2'd0, 10'd6,   11'd70,   1'b1, 4'd6}, // R6 touch one, high
    '{2'd2, 1'b0, 4'd1, 2'd1, 10'd60,  11'd70,   1'b0, 4'd6}, // R6 touch zero
    '{2'd1, 1'b1, 4'd3, 2'd0, 10'd6,   11'd70,   1'b0, 4'd7}, // R7 stretch 3
    '{2'd3, 1'b0, 4'd2, 2'd1, 10'd6,   11'd70,   1'b0, 4'd7}, // R7 stretch 2
    '{2'd1, 1'b0, 4'd0, 2'd0, 10'd60,  11'd70,   1'b0, 4'd7}  // R7 zero acts as one
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
  endtask

  task automatic run_slot(input logic [1:0] op, input logic bt, input logic [3:0] st,
                          input logic [1:0] dev, input bit inject, input int hold,
                          output int low_n, output int tot_n, output logic got,
                          output int inj_bad);
    int cs;
    cs = CPU * ((st == 4'd0) ? 1 : int'(st));
    low_n = 0; tot_n = 0; got = 1'bx; inj_bad = 0;
    @(negedge clk);
    stretch_i = st; cmd_op = op; cmd_bit = bt; cmd_valid = 1'b1;
    rsp_ready = (hold == 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (dev == 2'd1) dev_low = (k < 20 * cs);
      else if (dev == 2'd2) dev_low = (k >= 530 * cs) && (k < 650 * cs);
      else dev_low = 1'b0;
      if (inject) begin
        if (k == 10) begin cmd_valid = 1'b1; cmd_op = 2'd0; end
        if (k >= 10 && k < 100 && cmd_ready) inj_bad++;
        if (k == 100) cmd_valid = 1'b0;
      end
      if (rsp_valid) break;
      if (line_pull_low) low_n++;
      tot_n++;
      @(negedge clk);
    end
    dev_low = 1'b0;
    got = rsp_bit;
    if (hold > 0) begin
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(rsp_valid && busy && rsp_bit == got, "R9 stall hold", int'(rsp_bit), int'(got));
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      chk(!rsp_valid && !busy, "R9 idle after handshake", int'(busy), 0);
    end else begin
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int   lo, to, bad, cs;
    logic g;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready && !busy && !rsp_valid && !line_pull_low, "R1 idle after reset",
        {cmd_ready, busy, rsp_valid, line_pull_low}, 4'b1000);

    for (int i = 0; i < NV; i++) begin
      cs = CPU * ((VEC[i].st == 4'd0) ? 1 : int'(VEC[i].st));
      run_slot(VEC[i].op, VEC[i].bt, VEC[i].st, VEC[i].dev, 1'b0, 0, lo, to, g, bad);
      chk(lo == int'(VEC[i].low_us) * cs, $sformatf("R%0d low width vec %0d", VEC[i].rq, i),
          lo, int'(VEC[i].low_us) * cs);
      chk(to == int'(VEC[i].tot_us) * cs, $sformatf("R%0d slot length vec %0d", VEC[i].rq, i),
          to, int'(VEC[i].tot_us) * cs);
      chk(g === VEC[i].exp_bit, $sformatf("R%0d result vec %0d", VEC[i].rq, i),
          int'(g), int'(VEC[i].exp_bit));
    end

    // R8: a command offered while busy is neither accepted nor started later
    run_slot(2'd1, 1'b0, 4'd1, 2'd0, 1'b1, 0, lo, to, g, bad);
    chk(bad == 0, "R8 ready while busy", bad, 0);
    chk(lo == 60 * CPU && to == 70 * CPU, "R8 slot unchanged by offer", to, 70 * CPU);
    repeat (5) @(negedge clk);
    chk(!busy && !line_pull_low && cmd_ready, "R8 no slot from ignored offer",
        {busy, line_pull_low}, 0);

    // R9: stalled response on a read with the line high
    run_slot(2'd3, 1'b0, 4'd1, 2'd0, 1'b0, 12, lo, to, g, bad);
    chk(g === 1'b1, "R9 stalled result value", int'(g), 1);

    // R5 with stretch: absent device, twice every interval
    run_slot(2'd0, 1'b0, 4'd2, 2'd0, 1'b0, 0, lo, to, g, bad);
    chk(lo == 1000 * CPU && to == 2000 * CPU && g === 1'b1, "R5 stretched reset",
        to, 2000 * CPU);

    summary();
    $finish;
  end
endmodule